// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder

This block sits on the transmit path of a 100 Mb/s physical layer, right after the media-independent nibble interface. Each clock it takes one 4-bit nibble, the frame-enable and error flags, and emits one registered 5-bit code group. Between frames it sends the idle code. When a frame begins, the first two preamble nibbles are overwritten with the start delimiter. When a frame ends, two end-delimiter symbols are added. A nibble flagged as erroneous is replaced by the error symbol. Scrambling, line coding and serialization happen downstream and are not part of this block.

The stream runs at a fixed rate: one code group leaves for every nibble that enters. `tx_en` acts as the valid qualifier for a frame. There is no ready signal and no back-pressure, because the downstream serializer takes a symbol on every clock without exception. `enc_en` and `mii_mode` are plain control levels. When `enc_en` is cleared while `mii_mode` is set, the encoder is bypassed. Each nibble then passes through raw, with `tx_er` placed in front of it as the fifth bit.

Top module: `sym45_tx_encoder`

## Requirements
- R1: In a data cycle with `tx_er` low, nibble values 0 to 15 produce 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101 respectively (code shown MSB first, `code_o[4:0]`).
- R2: When no frame is in progress and `tx_en` is low, the output is the idle code 11111.
- R3: The first `tx_en`-high cycle after idle produces J (11000). The second produces K (10001). Data encoding begins on the third. An error flag during the J or K cycle has no effect.
- R4: In the first cycle with `tx_en` low after a started frame, the output is T (01101). This includes a frame that drops after only its J cycle.
- R5: The cycle after T always produces R (00111), even if `tx_en` is high in that cycle. The encoder then returns to idle, and the next `tx_en`-high cycle produces J.
- R6: In a data cycle with `tx_er` high, the output is the error symbol H (00100) whatever the nibble.
- R7: With `enc_en`=0 and `mii_mode`=1, the output is {`tx_er`, `txd`} every cycle, and the delimiter sequencing returns to idle.
- R8: With `enc_en`=0 and `mii_mode`=0, the encoder behaves exactly as with `enc_en`=1.
- R9: Every code group appears on `code_o` exactly one clock after the inputs that produced it are sampled.
- R10: While `rst_n` is low and in the first cycle after release, the output is the idle code 11111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low synchronous reset to idle |
| tx_en | input | 1 | Frame-enable / nibble-valid qualifier |
| tx_er | input | 1 | Transmit error flag for the current nibble |
| txd | input | 4 | Transmit nibble |
| enc_en | input | 1 | Encoding enable; clearing it requests raw bypass |
| mii_mode | input | 1 | Set when the MAC side runs the nibble interface; bypass only honoured here |
| code_o | output | 5 | Registered 5-bit code group |

## Verification
Every result is due one clock after its inputs: a nibble driven before edge n appears on `code_o` after edge n. This holds for delimiters, error symbols and raw bypass alike. The bench drives inputs on the falling edge and computes the expected symbol at that moment. It then queues that symbol and compares it at the next falling edge, which is one rising edge later. Multi-cycle orderings such as J then K, T then R, and a `tx_en` rise swallowed during R follow from this. The reference model carries the frame phase from one cycle to the next, so each symbol is still checked exactly one edge after the nibble that caused it.

// File: rtl/sym45_pkg.sv
package sym45_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam int NIB_N = 1 << NIB_W;

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_H    = 5'b00100;

  // frame phase held between clocks
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_K    = 2'd1,
    PH_DATA = 2'd2,
    PH_R    = 2'd3
  } tx_phase_e;

  // which symbol the current cycle carries
  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_J    = 3'd1,
    SEL_K    = 3'd2,
    SEL_T    = 3'd3,
    SEL_R    = 3'd4,
    SEL_H    = 3'd5,
    SEL_DATA = 3'd6
  } sym_sel_e;

  function automatic logic [SYM_W-1:0] nib_to_sym(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // true for any code group the encoder may legally send
  function automatic logic sym_is_legal(input logic [SYM_W-1:0] s);
    logic hit;
    hit = (s == SYM_IDLE) || (s == SYM_J) || (s == SYM_K) ||
          (s == SYM_T) || (s == SYM_R) || (s == SYM_H);
    for (int i = 0; i < NIB_N; i++) begin
      if (nib_to_sym(NIB_W'(i)) == s) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/sym45_nibble_map.sv
module sym45_nibble_map
  import sym45_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SYM_W-1:0] sym_o
);

  always_comb sym_o = nib_to_sym(nib_i);

endmodule

// File: rtl/sym45_frame_ctl.sv
module sym45_frame_ctl
  import sym45_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold_i,
  input  logic     tx_en_i,
  input  logic     tx_er_i,
  output sym_sel_e sel_o
);

  tx_phase_e ph_q, ph_d;

  always_comb begin
    ph_d  = ph_q;
    sel_o = SEL_IDLE;
    unique case (ph_q)
      PH_IDLE: begin
        if (tx_en_i) begin
          sel_o = SEL_J;
          ph_d  = PH_K;
        end
      end
      PH_K: begin
        if (tx_en_i) begin
          sel_o = SEL_K;
          ph_d  = PH_DATA;
        end else begin
          sel_o = SEL_T;
          ph_d  = PH_R;
        end
      end
      PH_DATA: begin
        if (tx_en_i) begin
          sel_o = tx_er_i ? SEL_H : SEL_DATA;
        end else begin
          sel_o = SEL_T;
          ph_d  = PH_R;
        end
      end
      default: begin
        // end delimiter always completes; tx_en here is not looked at
        sel_o = SEL_R;
        ph_d  = PH_IDLE;
      end
    endcase
    if (hold_i) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  AST_DATA_AFTER_K: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |-> $past(ph_q == PH_K || ph_q == PH_DATA)); // R3

  AST_R_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_R) |=> (ph_q == PH_IDLE)); // R5

endmodule

// File: rtl/sym45_out_reg.sv
module sym45_out_reg #(
  parameter int               W     = 6,
  parameter logic [W-1:0]     RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q_o[b] <= RST_V[b];
      else        q_o[b] <= d_i[b];
    end
  end

endmodule

// File: rtl/sym45_tx_encoder.sv
module sym45_tx_encoder
  import sym45_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  input  logic             enc_en,
  input  logic             mii_mode,
  output logic [SYM_W-1:0] code_o
);

  localparam int REG_W = SYM_W + 1;

  logic             raw_mode;
  sym_sel_e         sel;
  logic [SYM_W-1:0] data_sym;
  logic [SYM_W-1:0] sym_d;
  logic [REG_W-1:0] reg_q;
  logic             raw_q;

  // raw pass-through only when the MAC side uses the nibble interface
  assign raw_mode = !enc_en && mii_mode;

  sym45_nibble_map u_map (
    .nib_i (txd),
    .sym_o (data_sym)
  );

  sym45_frame_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (raw_mode),
    .tx_en_i (tx_en),
    .tx_er_i (tx_er),
    .sel_o   (sel)
  );

  always_comb begin
    unique case (sel)
      SEL_J:    sym_d = SYM_J;
      SEL_K:    sym_d = SYM_K;
      SEL_T:    sym_d = SYM_T;
      SEL_R:    sym_d = SYM_R;
      SEL_H:    sym_d = SYM_H;
      SEL_DATA: sym_d = data_sym;
      default:  sym_d = SYM_IDLE;
    endcase
    if (raw_mode) sym_d = {tx_er, txd};
  end

  sym45_out_reg #(
    .W     (REG_W),
    .RST_V ({1'b0, SYM_IDLE})
  ) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({raw_mode, sym_d}),
    .q_o   (reg_q)
  );

  assign raw_q  = reg_q[REG_W-1];
  assign code_o = reg_q[SYM_W-1:0];

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_q |-> sym_is_legal(code_o)); // R1

  AST_K_OR_T_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_q && !raw_mode && code_o == SYM_J) |=> (code_o == SYM_K || code_o == SYM_T)); // R3

  AST_R_AFTER_T: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_q && !raw_mode && code_o == SYM_T) |=> (code_o == SYM_R)); // R4

  AST_IDLE_OR_J_AFTER_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_q && !raw_mode && code_o == SYM_R) |=> (code_o == SYM_IDLE || code_o == SYM_J)); // R5

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rst_n) |-> (code_o == SYM_IDLE)); // R10

endmodule

// File: tb/test_sym45_tx_encoder.sv
module test_sym45_tx_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       enc_en = 1'b1;
  logic       mii_mode = 1'b1;
  logic [4:0] code_o;

  int n_chk = 0;
  int n_err = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  logic [4:0] tab [16];
  int         phase = 0; // 0 between frames, 1 start seen, 2 in payload, 3 tail owed

  always #2 clk = ~clk; // 250 MHz

  sym45_tx_encoder i_sym45_tx_encoder (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .enc_en(enc_en), .mii_mode(mii_mode), .code_o(code_o)
  );

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: code_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // behavioural reference: expected symbol for the inputs of this cycle
  task automatic model(input logic en, input logic er, input logic [3:0] d,
                       input logic enc, input logic mii);
    logic [4:0] e;
    string t;
    if (!enc && mii) begin
      phase = 0; e = {er, d}; t = "R7";
    end else if (phase == 0) begin
      if (en) begin phase = 1; e = 5'b11000; t = "R3"; end
      else begin e = 5'b11111; t = "R2"; end
    end else if (phase == 1) begin
      if (en) begin phase = 2; e = 5'b10001; t = "R3"; end
      else begin phase = 3; e = 5'b01101; t = "R4"; end
    end else if (phase == 2) begin
      if (!en) begin phase = 3; e = 5'b01101; t = "R4"; end
      else if (er) begin e = 5'b00100; t = "R6"; end
      else begin e = tab[d]; t = "R1"; end
    end else begin
      phase = 0; e = 5'b00111; t = "R5";
    end
    if (!enc && !mii) t = {t, "+R8"};
    exp_q.push_back(e);
    tag_q.push_back({t, "+R9"}); // R9: due one edge later
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic enc = 1'b1, input logic mii = 1'b1);
    @(negedge clk);
    if (exp_q.size() > 0) check(code_o, exp_q.pop_front(), tag_q.pop_front());
    tx_en = en; tx_er = er; txd = d; enc_en = enc; mii_mode = mii;
    model(en, er, d, enc, mii);
  endtask

  task automatic frame(input int len, input int err_at, input logic enc, input logic mii);
    for (int i = 0; i < len; i++)
      step(1'b1, (i == err_at), 4'((i * 7 + 3) % 16), enc, mii);
  endtask

  initial begin
    tab = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
            5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
            5'b11010, 5'b11011, 5'b11100, 5'b11101};
    fork
      begin
        repeat (3) @(negedge clk);
        check(code_o, 5'b11111, "R10 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        model(1'b0, 1'b0, 4'h0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 4'h0); // compares first post-reset symbol (R10)
        step(1'b0, 1'b0, 4'h0);
        // preamble then every nibble value, with error on J/K cycles ignored
        step(1'b1, 1'b1, 4'h5);
        step(1'b1, 1'b1, 4'h5);
        for (int v = 0; v < 16; v++) step(1'b1, 1'b0, 4'(v));
        step(1'b1, 1'b1, 4'h9);   // R6
        step(1'b1, 1'b0, 4'h2);
        step(1'b0, 1'b0, 4'h0);   // T
        step(1'b1, 1'b0, 4'h5);   // R despite tx_en high (R5)
        step(1'b1, 1'b0, 4'h5);   // J
        frame(6, 3, 1'b1, 1'b1);
        step(1'b0, 1'b0, 4'h0);
        step(1'b0, 1'b0, 4'h0);
        step(1'b0, 1'b0, 4'h0);
        // frame dropped after J only
        step(1'b1, 1'b0, 4'h5);
        step(1'b0, 1'b0, 4'h0);
        step(1'b0, 1'b0, 4'h0);
        step(1'b0, 1'b0, 4'h0);
        // raw bypass (R7)
        for (int v = 0; v < 8; v++) step(v[0], v[1], 4'(v * 3 + 1), 1'b0, 1'b1);
        step(1'b0, 1'b0, 4'h0);
        step(1'b0, 1'b0, 4'h0);
        // bypass requested but not honoured (R8)
        frame(7, 4, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule